// File: doc/BRIEF.md
# Single-Level Page Table Walker

This engine services a translation-buffer miss. A miss request arrives with a virtual page number and a flag telling whether the access was a write. The walker latches the request and the page-table base, computes the entry address as base plus page number times four bytes, and issues one read on a valid/ready memory port. Pages are a fixed 4 KB, so the low twelve bits of an address are never translated and never reach this block.

A fetched entry is decoded as follows: bit 31 is the present flag, bit 30 the reference flag, bit 29 the dirty flag, and bits 19:0 the physical page number. If the entry is not present, the walker answers with a fault indication and leaves recovery to software, with no memory write. If it is present, the walker sets the reference flag, and also sets the dirty flag when the access is a write. The updated entry is written back to the same address, but only if one of the flags actually changed. After that, the walker returns a refill record so that the faulting access can be retried.

One request is handled at a time. A busy signal stays high from the acceptance of a request until the requester accepts the response.

Top module: `ptw_top`

## Requirements
- R1: For each accepted request the walker issues exactly one memory read, at address `base_addr + req_vpn*4`, truncated to the address width. A memory request holds its address and direction until it is accepted.
- R2: Entry fields are decoded at fixed bit positions: present = bit 31, reference = bit 30, dirty = bit 29, physical page number = bits 19:0.
- R3: When the fetched entry has bit 31 clear, the response carries `resp_fault`=1 and no memory write is issued.
- R4: When the fetched entry has bit 31 set, the response carries `resp_fault`=0 and `resp_ppn` equal to entry bits 19:0.
- R5: On any access to a present entry, the reference bit becomes 1. The response reports `resp_ref`=1, and any write-back has bit 30 set.
- R6: On a write access to a present entry, the dirty bit becomes 1. On a read access it keeps its fetched value. The response reports the resulting dirty bit.
- R7: A write-back of the updated entry to the entry address is issued only when the reference or dirty bit changed, and at most once per request.
- R8: Any write-back is accepted by memory before `resp_valid` rises. A memory request and a response are never offered in the same cycle.
- R9: `busy` is high from the cycle after a request handshake until the cycle after a response handshake. `req_ready` is low whenever `busy` is high, so requests offered meanwhile are not taken.
- R10: After reset, `busy`=0, `req_ready`=1, `resp_valid`=0 and `mem_req_valid`=0.
- R11: While `resp_valid` is high and `resp_ready` is low, the response fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Walker can accept a request |
| req_vpn | input | 20 | Virtual page number of the miss |
| req_write | input | 1 | Miss came from a write access |
| base_addr | input | 32 | Physical address of the page table start |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write-back, 0 = entry read |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Fetched entry |
| resp_valid | output | 1 | Refill or fault response offered |
| resp_ready | input | 1 | Requester accepts the response |
| resp_fault | output | 1 | 1 = entry not present |
| resp_vpn | output | 20 | Page number the response belongs to |
| resp_ppn | output | 20 | Physical page number for refill |
| resp_ref | output | 1 | Reference bit after update |
| resp_dirty | output | 1 | Dirty bit after update |
| busy | output | 1 | A walk is in progress |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, a 12-bit page offset, a 20-bit frame number and 32-bit entries. With these values the largest page number, combined with a base near the top of the address space, makes the entry address wrap. A later request to an entry the walker has already rewritten shows whether its write-back really reached memory. Memory and response stalls follow a pseudo-random pattern, so every handshake is exercised both with and without back-pressure. A new request is always offered while the previous walk is still busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENTRY_PRESENT_BIT = 31;
  localparam int ENTRY_REF_BIT     = 30;
  localparam int ENTRY_DIRTY_BIT   = 29;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH,
    W_WAIT,
    W_WBACK,
    W_REPLY
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W      = 32,
  parameter int VPN_W     = 20,
  parameter int ENTRY_W   = 32
) (
  input  logic [PA_W-1:0]  table_base,
  input  logic [VPN_W-1:0] page_num,
  output logic [PA_W-1:0]  entry_addr
);
  localparam int ENTRY_BYTES = ENTRY_W / 8;
  localparam int IDX_SHIFT   = $clog2(ENTRY_BYTES);

  // base plus index scaled by entry size, wrapping at the address width
  function automatic logic [PA_W-1:0] locate(input logic [PA_W-1:0] base,
                                             input logic [VPN_W-1:0] idx);
    logic [PA_W-1:0] scaled;
    scaled = PA_W'(idx) << IDX_SHIFT;
    return base + scaled;
  endfunction

  assign entry_addr = locate(table_base, page_num);
endmodule

// File: rtl/ptw_status_upd.sv
module ptw_status_upd
  import ptw_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] entry_in,
  input  logic               is_write,
  output logic [ENTRY_W-1:0] entry_out,
  output logic               present,
  output logic               changed
);
  function automatic logic [ENTRY_W-1:0] mark(input logic [ENTRY_W-1:0] e,
                                              input logic wr);
    logic [ENTRY_W-1:0] r;
    r = e;
    r[ENTRY_REF_BIT] = 1'b1;
    if (wr) r[ENTRY_DIRTY_BIT] = 1'b1;
    return r;
  endfunction

  assign present   = entry_in[ENTRY_PRESENT_BIT];
  assign entry_out = mark(entry_in, is_write);
  assign changed   = present && (entry_out != entry_in);
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int PA_W    = 32,
  parameter int VPN_W   = 20,
  parameter int ENTRY_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic               req_write,
  input  logic [PA_W-1:0]    base_addr,
  output logic               busy,
  output logic [PA_W-1:0]    base_q,
  output logic [VPN_W-1:0]   vpn_q,
  output logic               wr_q,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  input  logic               mem_rsp_valid,
  input  logic               upd_present,
  input  logic               upd_changed,
  input  logic [ENTRY_W-1:0] upd_entry,
  input  logic [ENTRY_W-1:0] raw_entry,
  output logic [ENTRY_W-1:0] entry_q,
  output logic               fault_q,
  output logic               resp_valid,
  input  logic               resp_ready
);
  walk_state_e st, st_nx;
  logic [ENTRY_W-1:0] orig_q;

  // named internal events
  logic req_take, entry_fetch, wb_done, reply_done;
  assign req_take    = (st == W_IDLE) && req_valid;
  assign entry_fetch = (st == W_WAIT) && mem_rsp_valid;
  assign wb_done     = (st == W_WBACK) && mem_req_ready;
  assign reply_done  = (st == W_REPLY) && resp_ready;

  always_comb begin
    st_nx = st;
    unique case (st)
      W_IDLE:  if (req_valid) st_nx = W_FETCH;
      W_FETCH: if (mem_req_ready) st_nx = W_WAIT;
      W_WAIT:  if (mem_rsp_valid) st_nx = (upd_present && upd_changed) ? W_WBACK : W_REPLY;
      W_WBACK: if (mem_req_ready) st_nx = W_REPLY;
      W_REPLY: if (resp_ready) st_nx = W_IDLE;
      default: st_nx = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      base_q  <= '0;
      vpn_q   <= '0;
      wr_q    <= 1'b0;
      entry_q <= '0;
      orig_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (req_take) begin
        base_q <= base_addr;
        vpn_q  <= req_vpn;
        wr_q   <= req_write;
      end
      if (entry_fetch) begin
        orig_q  <= raw_entry;
        entry_q <= upd_present ? upd_entry : raw_entry;
        fault_q <= !upd_present;
      end
    end
  end

  assign req_ready     = (st == W_IDLE);
  assign busy          = (st != W_IDLE);
  assign mem_req_valid = (st == W_FETCH) || (st == W_WBACK);
  assign mem_req_we    = (st == W_WBACK);
  assign resp_valid    = (st == W_REPLY);

  // R3: a missing entry goes straight to a fault reply
  a_r3_fault_skips_write: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fetch && !upd_present |=> resp_valid && fault_q);
  // R7: a write-back always carries a changed entry
  a_r7_wb_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> entry_q != orig_q);
  // R6: write accesses leave the dirty flag set in the write-back
  a_r6_dirty_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && wr_q |-> entry_q[ENTRY_DIRTY_BIT]);
  // R9: no new request while a walk runs
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R8: the reply follows the write-back acceptance
  a_r8_reply_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> resp_valid);
  // R11: reply held until taken
  a_r11_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !reply_done |=> resp_valid && $stable(entry_q) && $stable(fault_q));
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_OFS_W = 12,
  parameter int PA_W       = 32,
  parameter int PPN_W      = 20,
  parameter int ENTRY_W    = 32,
  localparam int VPN_W     = VA_W - PAGE_OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic               req_write,
  input  logic [PA_W-1:0]    base_addr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic [ENTRY_W-1:0] mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic               resp_fault,
  output logic [VPN_W-1:0]   resp_vpn,
  output logic [PPN_W-1:0]   resp_ppn,
  output logic               resp_ref,
  output logic               resp_dirty,
  output logic               busy
);
  logic [PA_W-1:0]    base_q;
  logic [VPN_W-1:0]   vpn_q;
  logic               wr_q;
  logic [ENTRY_W-1:0] upd_entry, entry_q;
  logic               upd_present, upd_changed, fault_q;

  ptw_addr_gen #(.PA_W(PA_W), .VPN_W(VPN_W), .ENTRY_W(ENTRY_W)) u_addr (
    .table_base(base_q), .page_num(vpn_q), .entry_addr(mem_req_addr));

  ptw_status_upd #(.ENTRY_W(ENTRY_W)) u_upd (
    .entry_in(mem_rsp_data), .is_write(wr_q), .entry_out(upd_entry),
    .present(upd_present), .changed(upd_changed));

  ptw_fsm #(.PA_W(PA_W), .VPN_W(VPN_W), .ENTRY_W(ENTRY_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .req_write(req_write), .base_addr(base_addr), .busy(busy),
    .base_q(base_q), .vpn_q(vpn_q), .wr_q(wr_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_rsp_valid(mem_rsp_valid),
    .upd_present(upd_present), .upd_changed(upd_changed),
    .upd_entry(upd_entry), .raw_entry(mem_rsp_data),
    .entry_q(entry_q), .fault_q(fault_q),
    .resp_valid(resp_valid), .resp_ready(resp_ready));

  assign mem_req_wdata = entry_q;
  assign resp_fault    = fault_q;
  assign resp_vpn      = vpn_q;
  assign resp_ppn      = entry_q[PPN_W-1:0];
  assign resp_ref      = entry_q[ENTRY_REF_BIT];
  assign resp_dirty    = entry_q[ENTRY_DIRTY_BIT];

  // R1: memory request held stable under back-pressure
  a_r1_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
  // R8: never a memory request and a reply together
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && resp_valid));
  // R5: every write-back carries the reference flag
  a_r5_ref_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[ENTRY_REF_BIT]);
  // R11: reply fields held until accepted
  a_r11_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> $stable(resp_ppn) && $stable(resp_dirty) && $stable(resp_vpn));
endmodule

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_vpn = '0;
  logic [31:0] base_addr = '0;
  logic req_ready, mem_req_valid, mem_req_we, resp_valid, resp_fault, resp_ref, resp_dirty, busy;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, resp_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data = '0;
  logic [19:0] resp_vpn, resp_ppn;

  always #10 clk = ~clk;

  ptw_top dut (.*);

  int compared = 0, mismatched = 0;
  logic [31:0] tbl [0:255];
  int acc_cnt = 0, done_cnt = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int slot(input logic [31:0] a);
    return int'(a[9:2]);
  endfunction

  // reference model state, one walk at a time
  bit exp_busy = 0, rd_pend = 0, hold_prev = 0, rsp_seen = 0;
  int rd_idx = 0, rd_cnt = 0, wr_cnt = 0, exp_wr = 0;
  logic [31:0] x_addr, x_entry, x_new;
  logic x_write;
  logic [19:0] x_vpn, p_ppn;
  logic p_fault, p_dirty;
  logic [7:0] lfsr = 8'h5A;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == exp_busy, "R9 busy", {31'd0, busy}, {31'd0, exp_busy});
      check(req_ready == !exp_busy, "R9 req_ready", {31'd0, req_ready}, {31'd0, !exp_busy});
      if (resp_valid && !rsp_seen) begin
        check(wr_cnt == exp_wr, "R8 write-back before reply", wr_cnt, exp_wr);
        rsp_seen = 1;
      end
      if (hold_prev) begin
        check(resp_valid && resp_ppn == p_ppn && resp_fault == p_fault && resp_dirty == p_dirty,
              "R11 reply held", {resp_valid, resp_fault, resp_dirty, 9'd0, resp_ppn},
              {1'b1, p_fault, p_dirty, 9'd0, p_ppn});
      end
      // memory read return
      mem_rsp_valid = 1'b0;
      if (rd_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = tbl[rd_idx];
        rd_pend = 0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = lfsr[0] | lfsr[1];
      resp_ready    = lfsr[2] | lfsr[4];
      if (mem_req_valid && mem_req_ready) begin
        check(mem_req_addr == x_addr, "R1 entry address", mem_req_addr, x_addr);
        if (mem_req_we) begin
          wr_cnt++;
          check(exp_wr == 1 && wr_cnt == 1, "R7 write-back allowed", wr_cnt, exp_wr);
          check(mem_req_wdata == x_new, "R5 R6 write-back data", mem_req_wdata, x_new);
          tbl[slot(mem_req_addr)] = mem_req_wdata;
        end else begin
          rd_cnt++;
          check(rd_cnt == 1, "R1 single read", rd_cnt, 1);
          rd_idx = slot(mem_req_addr);
          rd_pend = 1;
        end
      end
      if (resp_valid && resp_ready) begin
        check(resp_fault == !x_entry[31], "R3 R4 fault flag", {31'd0, resp_fault}, {31'd0, !x_entry[31]});
        check(wr_cnt == exp_wr, "R7 write-back count", wr_cnt, exp_wr);
        check(resp_vpn == x_vpn, "R4 reply page", {12'd0, resp_vpn}, {12'd0, x_vpn});
        if (x_entry[31]) begin
          check(resp_ppn == x_entry[19:0], "R2 R4 frame number", {12'd0, resp_ppn}, {12'd0, x_entry[19:0]});
          check(resp_ref == 1'b1, "R5 reference", {31'd0, resp_ref}, 32'd1);
          check(resp_dirty == x_new[29], "R6 dirty", {31'd0, resp_dirty}, {31'd0, x_new[29]});
        end
        exp_busy = 0;
        rsp_seen = 0;
        done_cnt++;
      end
      hold_prev = resp_valid && !resp_ready;
      p_ppn = resp_ppn; p_fault = resp_fault; p_dirty = resp_dirty;
      if (req_valid && req_ready) begin
        x_vpn   = req_vpn;
        x_write = req_write;
        x_addr  = base_addr + {req_vpn, 2'b00};
        x_entry = tbl[slot(x_addr)];
        x_new   = x_entry | 32'h4000_0000 | (req_write ? 32'h2000_0000 : 32'h0);
        exp_wr  = (x_entry[31] && x_new != x_entry) ? 1 : 0;
        exp_busy = 1;
        rd_cnt = 0; wr_cnt = 0;
        acc_cnt++;
      end
    end
  end

  task automatic issue(input logic [31:0] base, input logic [19:0] vpn, input logic wr,
                       input bit preload, input logic [31:0] entry);
    int a;
    if (preload) tbl[slot(base + {vpn, 2'b00})] = entry;
    base_addr = base; req_vpn = vpn; req_write = wr; req_valid = 1'b1;
    a = acc_cnt;
    while (acc_cnt == a) begin @(posedge clk); #5; end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tbl[i] = 32'h0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(posedge clk); #5;
    check(!busy && req_ready && !resp_valid && !mem_req_valid, "R10 reset state",
          {28'd0, busy, req_ready, resp_valid, mem_req_valid}, 32'h4);
    issue(32'h0000_1000, 20'd3, 1'b0, 1, 32'h0000_0000);   // R3 fault on read
    issue(32'h0000_1000, 20'd4, 1'b1, 1, 32'h6000_0123);   // R3 fault on write, flags set but absent
    issue(32'h0000_1000, 20'd5, 1'b0, 1, 32'h8001_2345);   // R5 ref set
    issue(32'h0000_1000, 20'd6, 1'b0, 1, 32'hC00A_BCDE);   // R7 nothing changes
    issue(32'h0000_1000, 20'd7, 1'b1, 1, 32'hC000_0011);   // R6 dirty set
    issue(32'h0000_1000, 20'd8, 1'b1, 1, 32'hE00F_FFFF);   // R7 nothing changes on write
    issue(32'h0000_1000, 20'd9, 1'b1, 1, 32'h8000_0042);   // R5 R6 both change
    issue(32'hFFFF_F000, 20'hFFFFF, 1'b0, 1, 32'h8000_0007); // R1 address wrap
    issue(32'h0000_1000, 20'd5, 1'b0, 0, 32'h0);            // R7 entry already updated in memory
    issue(32'h0000_1000, 20'd5, 1'b1, 0, 32'h0);            // R6 dirty after earlier ref update
    req_valid = 1'b0;
    while (done_cnt < 10) begin @(posedge clk); #5; end
    check(tbl[slot(32'h0000_1000 + 20)] == 32'hE001_2345, "R7 final entry in memory",
          tbl[slot(32'h0000_1000 + 20)], 32'hE001_2345);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d done walks", done_cnt, 10);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule